// File: doc/BRIEF.md
# Serial Avionics Word Receiver

This block takes in 32-bit serial avionics data words. They arrive as two return-to-zero digital lines. A pulse on one line means a One bit and a pulse on the other means a Zero bit. A rising edge on either line is a bit event. Each bit is shifted into a 32-bit assembly register. The first bit received ends up in bit 0 of the word. A second pair of digital test inputs can stand in for the line inputs. While either test input is high, the selected source is the test pair and the line inputs have no effect.

A word ends when no bit event has been seen for a set number of rising edges of a separate, slow, asynchronous gap clock. At that point the bit count and, optionally, odd parity are judged. A good word is copied into a 32-bit holding buffer. The buffer is read out as two 16-bit beats on a valid/ready stream. A bad word only raises the error output.

The stream rules are as follows. `out_valid` stays high, and `out_data`/`out_last` stay unchanged, until the consumer accepts with `out_ready`. The one exception is a newly completed good word, which overwrites the buffer and restarts at the low half. Back-pressure never stalls reception.

Top module: `a429_word_rx`

## Requirements
- R1: A rising edge on the One source shifts a 1 into the word and a rising edge on the Zero source shifts a 0; the first bit received lands in word bit 0 and the 32nd in word bit 31.
- R2: If both sources are high in the same cycle anywhere within a word, that word is flagged as an error and not loaded.
- R3: A word ends after 16 gap-clock rising edges with no bit event; with the gap clock asynchronous, data-ready appears between 15 and 17 gap periods after the last bit.
- R4: A word of exactly 32 bits that passes the parity rule is loaded, `out_valid` rises with `out_last`=0, and `err` goes to 0.
- R5: A word whose bit count is not 32 sets `err` to 1 and leaves the buffer and `out_valid` unchanged.
- R6: With `par_en`=1 a word with an even number of ones is an error; with `par_en`=0 parity is not checked.
- R7: The first beat carries word bits 15:0 with `out_last`=0, the second carries bits 31:16 with `out_last`=1, and `out_valid` falls after the second beat is accepted.
- R8: While `out_valid`=1 and `out_ready`=0, `out_data` and `out_last` hold steady unless a new good word completes.
- R9: While either test input is high, the line inputs are ignored and the word comes from the test inputs.
- R10: A good word completing while the buffer still holds an unread word replaces it and the next beat is the new word's low half.
- R11: Reset clears `out_valid` and `err` and returns the half pointer to the low half.
- R12: `err` is a level that keeps its value from one word end to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_one | input | 1 | One pulses from the line receiver (asynchronous) |
| line_zero | input | 1 | Zero pulses from the line receiver (asynchronous) |
| test_one | input | 1 | One pulses from the test path (asynchronous) |
| test_zero | input | 1 | Zero pulses from the test path (asynchronous) |
| gap_clk | input | 1 | Slow gap-timing clock (asynchronous) |
| par_en | input | 1 | 1 = enforce odd parity over the 32-bit word |
| out_valid | output | 1 | A half-word beat is available |
| out_ready | input | 1 | Consumer accepts the current beat |
| out_data | output | 16 | Current half of the held word |
| out_last | output | 1 | 1 on the high-half beat |
| err | output | 1 | Last completed word was rejected |

## Verification
The bench targets the gap window. A timer that counted one edge too few or too many would raise data-ready before 15 or after 17 gap periods. It also sends words one bit short and one bit long, which a counter that wrapped or did not saturate would accept. Parity is tried with the enable in both states. A both-lines-high bit is sent, which a design without the line-error check would load as data. On the stream side, the bench checks beat order and the drop of valid after the second beat. It also checks that data holds under back-pressure, that an unread word is overwritten, and that the half pointer is low again after a reset taken mid-read. A design that kept a stale pointer would return the high half first.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;
  // Pair of return-to-zero levels: one pulses for a One bit, zero for a Zero bit.
  typedef struct packed {
    logic one;
    logic zero;
  } a429_lv_t;

  // Lane order of the asynchronous inputs through the synchronizer.
  localparam int unsigned LN_ONE   = 0;
  localparam int unsigned LN_ZERO  = 1;
  localparam int unsigned TS_ONE   = 2;
  localparam int unsigned TS_ZERO  = 3;
  localparam int unsigned GAP_LANE = 4;
  localparam int unsigned N_LANES  = 5;
endpackage

// File: rtl/a429_sync.sv
module a429_sync #(
  parameter int unsigned LANES  = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] din,
  output logic [LANES-1:0] dout
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], din[g]};
    end
    assign dout[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/a429_word_asm.sv
module a429_word_asm
  import a429_rx_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  a429_lv_t          lv,
  input  logic              clear,
  output logic              bit_evt,
  output logic [WORD_W-1:0] word,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              line_err,
  output logic              active
);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(WORD_W + 1);

  a429_lv_t lv_q;
  logic     rise_one, rise_zero;

  assign rise_one  = lv.one  & ~lv_q.one;
  assign rise_zero = lv.zero & ~lv_q.zero;
  assign bit_evt   = rise_one | rise_zero;
  assign active    = (bit_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lv_q     <= '0;
      word     <= '0;
      bit_cnt  <= '0;
      line_err <= 1'b0;
    end else begin
      lv_q <= lv;
      if (clear) begin
        word     <= '0;
        bit_cnt  <= '0;
        line_err <= 1'b0;
      end else begin
        if (bit_evt) word <= {rise_one, word[WORD_W-1:1]};
        if (bit_evt && bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
        if (lv.one && lv.zero) line_err <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/a429_gap_timer.sv
module a429_gap_timer #(
  parameter int unsigned GAP_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gap_lv,
  input  logic bit_evt,
  input  logic active,
  output logic done
);
  localparam int unsigned CW = (GAP_CYC < 2) ? 1 : $clog2(GAP_CYC);
  localparam logic [CW-1:0] LAST = CW'(GAP_CYC - 1);

  logic          gap_q, gap_rise;
  logic [CW-1:0] cnt;

  assign gap_rise = gap_lv & ~gap_q;
  assign done     = active & gap_rise & ~bit_evt & (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q <= 1'b0;
      cnt   <= '0;
    end else begin
      gap_q <= gap_lv;
      if (bit_evt || !active) cnt <= '0;
      else if (gap_rise)      cnt <= done ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/a429_rx_buf.sv
module a429_rx_buf #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic              good,
  input  logic [WORD_W-1:0] word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [HALF_W-1:0] out_data,
  output logic              out_last,
  output logic              err
);
  logic [WORD_W-1:0] hold;
  logic              half;
  logic              load;

  assign load     = done & good;
  assign out_last = half;
  assign out_data = half ? hold[WORD_W-1 -: HALF_W] : hold[HALF_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold      <= '0;
      half      <= 1'b0;
      out_valid <= 1'b0;
      err       <= 1'b0;
    end else begin
      if (done) err <= ~good;
      if (load) begin
        hold      <= word;
        half      <= 1'b0;
        out_valid <= 1'b1;
      end else if (out_valid && out_ready) begin
        if (!half) begin
          half <= 1'b1;
        end else begin
          half      <= 1'b0;
          out_valid <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/a429_word_rx.sv
module a429_word_rx
  import a429_rx_pkg::*;
#(
  parameter int unsigned WORD_W      = 32,
  parameter int unsigned GAP_CYC     = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_one,
  input  logic              line_zero,
  input  logic              test_one,
  input  logic              test_zero,
  input  logic              gap_clk,
  input  logic              par_en,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W/2-1:0] out_data,
  output logic              out_last,
  output logic              err
);
  localparam int unsigned HALF_W = WORD_W / 2;
  localparam int unsigned CNT_W  = $clog2(WORD_W + 2);

  logic [N_LANES-1:0] raw, syn;
  a429_lv_t           line_lv, test_lv, sel_lv;
  logic               test_sel;
  logic               bit_evt, line_err, active;
  logic [WORD_W-1:0]  word;
  logic [CNT_W-1:0]   bit_cnt;
  logic               word_done, word_good;

  assign raw[LN_ONE]   = line_one;
  assign raw[LN_ZERO]  = line_zero;
  assign raw[TS_ONE]   = test_one;
  assign raw[TS_ZERO]  = test_zero;
  assign raw[GAP_LANE] = gap_clk;

  a429_sync #(.LANES(N_LANES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(raw), .dout(syn)
  );

  assign line_lv  = '{one: syn[LN_ONE], zero: syn[LN_ZERO]};
  assign test_lv  = '{one: syn[TS_ONE], zero: syn[TS_ZERO]};
  assign test_sel = test_lv.one | test_lv.zero;
  assign sel_lv   = test_sel ? test_lv : line_lv;

  a429_word_asm #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .lv(sel_lv), .clear(word_done),
    .bit_evt(bit_evt), .word(word), .bit_cnt(bit_cnt),
    .line_err(line_err), .active(active)
  );

  a429_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk(clk), .rst_n(rst_n), .gap_lv(syn[GAP_LANE]),
    .bit_evt(bit_evt), .active(active), .done(word_done)
  );

  // Exact count, no line error, and odd parity when enforced.
  assign word_good = (bit_cnt == CNT_W'(WORD_W)) && !line_err
                     && (!par_en || (^word));

  a429_rx_buf #(.WORD_W(WORD_W), .HALF_W(HALF_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .done(word_done), .good(word_good),
    .word(word), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .err(err)
  );
endmodule

// File: rtl/a429_word_rx_chk.sv
module a429_word_rx_chk #(
  parameter int unsigned HALF_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic [HALF_W-1:0] out_data,
  input logic              out_last,
  input logic              err,
  input logic              wd_done,
  input logic              wd_good
);
  p_good_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_done && wd_good) |=> (out_valid && !out_last && !err));

  p_bad_noload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_done && !wd_good && !out_valid) |=> (!out_valid && err));

  p_drop_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last && !(wd_done && wd_good)) |=> !out_valid);

  p_hold_bp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !(wd_done && wd_good))
      |=> (out_valid && $stable(out_data) && $stable(out_last)));

  p_err_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_done |=> $stable(err));
endmodule

bind a429_word_rx a429_word_rx_chk #(.HALF_W(WORD_W/2)) chk_i (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_last(out_last), .err(err),
  .wd_done(word_done), .wd_good(word_good)
);

// File: tb/a429_word_rx_tb_top.sv
`timescale 1ns/1ps
module a429_word_rx_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        line_one = 0, line_zero = 0, test_one = 0, test_zero = 0;
  logic        gap_clk = 0, par_en = 0, out_ready = 0;
  logic        out_valid, out_last, err;
  logic [15:0] out_data;
  int          n_checks = 0, n_fail = 0;

  a429_word_rx dut_i (
    .clk(clk), .rst_n(rst_n), .line_one(line_one), .line_zero(line_zero),
    .test_one(test_one), .test_zero(test_zero), .gap_clk(gap_clk),
    .par_en(par_en), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .err(err)
  );

  always #2.5 clk = ~clk;
  initial forever #50 gap_clk = ~gap_clk;  // asynchronous 10 MHz gap clock

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] odd_fix(input logic [31:0] w);
    logic [31:0] r = w;
    r[31] = ~(^w[30:0]);
    return r;
  endfunction

  // One RZ bit: 4 clocks high, 4 low. both=1 drives both sources (line error).
  task automatic pulse(input logic b, input logic both, input bit use_test, input bit junk);
    @(negedge clk);
    if (use_test) begin
      test_one = b | both; test_zero = ~b | both;
      if (junk) line_zero = 1'b1;
    end else begin
      line_one = b | both; line_zero = ~b | both;
    end
    repeat (4) @(negedge clk);
    line_one = 0; line_zero = 0; test_one = 0; test_zero = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_word(input logic [32:0] w, input int len, input bit use_test,
                           input int bad_idx, input bit junk);
    for (int i = 0; i < len; i++) pulse(w[i], i == bad_idx, use_test, junk);
  endtask

  task automatic settle();
    repeat (360) @(negedge clk);
  endtask

  task automatic read_word(input logic [31:0] w, input string req);
    @(negedge clk);
    check({req, " valid"}, {31'd0, out_valid}, 32'd1);
    check({req, " low half"}, {15'd0, out_last, out_data}, {16'd0, w[15:0]});
    out_ready = 1; @(negedge clk); out_ready = 0;
    check({req, " high half"}, {15'd0, out_last, out_data}, {15'd0, 1'b1, w[31:16]});
    out_ready = 1; @(negedge clk); out_ready = 0;
    check("R7 valid drops after second beat", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] w, w2;
    void'($urandom(32'd1429));
    repeat (5) @(negedge clk);
    check("R11 reset valid", {31'd0, out_valid}, 32'd0);
    check("R11 reset err", {31'd0, err}, 32'd0);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // R1/R3/R4/R7: directed word with gap-window check
    par_en = 1;
    w = odd_fix(32'h0000_0001);
    send_word({1'b0, w}, 32, 0, -1, 0);
    repeat (280) @(negedge clk);
    check("R3 not done before 15 gap periods", {31'd0, out_valid}, 32'd0);
    repeat (65) @(negedge clk);
    check("R3 done by 17 gap periods", {31'd0, out_valid}, 32'd1);
    check("R4 err low on good word", {31'd0, err}, 32'd0);
    read_word(w, "R1 first bit in bit0");

    // R2: both lines high in one bit
    w = odd_fix(32'h1234_5678);
    send_word({1'b0, w}, 32, 0, 9, 0); settle();
    check("R2 line error err", {31'd0, err}, 32'd1);
    check("R2 line error not loaded", {31'd0, out_valid}, 32'd0);
    repeat (100) @(negedge clk);
    check("R12 err held", {31'd0, err}, 32'd1);

    // R6: even parity with and without enable
    w = odd_fix(32'h00AB_CDEF) ^ 32'h1;
    par_en = 1; send_word({1'b0, w}, 32, 0, -1, 0); settle();
    check("R6 parity error", {31'd0, err}, 32'd1);
    check("R6 parity error not loaded", {31'd0, out_valid}, 32'd0);
    par_en = 0; send_word({1'b0, w}, 32, 0, -1, 0); settle();
    check("R6 parity ignored when disabled", {31'd0, err}, 32'd0);
    read_word(w, "R6 disabled parity word");

    // R9: test inputs override, line_zero pulses alongside
    par_en = 1;
    w = odd_fix(32'hFFFF_0F0F);
    send_word({1'b0, w}, 32, 1, -1, 1); settle();
    check("R9 test path err", {31'd0, err}, 32'd0);
    read_word(w, "R9 test path word");

    // R8 back-pressure, then R10 overwrite
    w = odd_fix(32'h5A5A_3C3C);
    send_word({1'b0, w}, 32, 0, -1, 0); settle();
    repeat (20) @(negedge clk);
    check("R8 data held under back-pressure", {15'd0, out_last, out_data}, {16'd0, w[15:0]});
    out_ready = 1; @(negedge clk); out_ready = 0;
    w2 = odd_fix(32'hC0DE_7711);
    send_word({1'b0, w2}, 32, 0, -1, 0); settle();
    read_word(w2, "R10 overwrite restarts low");

    // R11: reset mid-read
    w = odd_fix(32'h0F0F_F0F0);
    send_word({1'b0, w}, 32, 0, -1, 0); settle();
    out_ready = 1; @(negedge clk); out_ready = 0;
    rst_n = 0; repeat (3) @(negedge clk);
    check("R11 reset mid-read valid", {31'd0, out_valid}, 32'd0);
    rst_n = 1; repeat (3) @(negedge clk);
    w = odd_fix(32'h2468_ACE0);
    send_word({1'b0, w}, 32, 0, -1, 0); settle();
    read_word(w, "R11 pointer low after reset");

    // R5 directed: short and long words
    send_word({1'b0, w}, 31, 0, -1, 0); settle();
    check("R5 short word err", {31'd0, err}, 32'd1);
    check("R5 short word not loaded", {31'd0, out_valid}, 32'd0);
    send_word({1'b1, w}, 33, 0, -1, 0); settle();
    check("R5 long word err", {31'd0, err}, 32'd1);
    check("R5 long word not loaded", {31'd0, out_valid}, 32'd0);

    // Constrained random mix
    for (int k = 0; k < 10; k++) begin
      int  len;
      bit  pe, badp, good;
      int  sel = $urandom_range(0, 5);
      len  = (sel == 0) ? 31 : (sel == 1) ? 33 : 32;
      pe   = 1'($urandom_range(0, 1));
      badp = ($urandom_range(0, 2) == 0);
      w    = odd_fix($urandom());
      if (badp) w = w ^ 32'h1;
      good = (len == 32) && (!pe || !badp);
      par_en = pe;
      send_word({1'($urandom_range(0, 1)), w}, len, 0, -1, 0); settle();
      check("R5/R6 random err", {31'd0, err}, {31'd0, !good});
      if (good) read_word(w, "R4 random word");
      else check("R5 random reject", {31'd0, out_valid}, 32'd0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule